// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a configuration-space host port and the function slots of a single bus. A request arrives as one packed 24-bit address holding a bus number, a device/function index and a register offset, together with an access length, a read/write flag and write data. When the request names bus 0 and the indexed slot is present, it is passed on at once to a shared slot port. That port carries the slot index, the 8-bit register offset, the normalized length and the write data.

Writes to a missing target are dropped. Reads from a missing target complete with all-ones data of the requested width. Every request, hit or miss, read or write, produces exactly one response strobe one cycle after it is accepted.

A separate combinational helper looks at the slot presence map and proposes the slot for the next function to be placed automatically. It tries indices spaced 8 apart, starting from a parameterized minimum, and returns the first free one split into device and function numbers. It flags failure when every candidate is taken.

Top module: `cfg_route_top`

## Requirements
- R1: On a hit, in the same cycle, fwd_valid is 1, fwd_slot equals req_addr[15:8] and fwd_reg equals req_addr[7:0].
- R2: A request whose req_addr[23:16] is not zero is never forwarded, whatever the presence map says, and reads from it return all-ones data.
- R3: A read to a missing target returns rsp_rdata 32'h0000_00FF for req_len 1, 32'h0000_FFFF for req_len 2, and 32'hFFFF_FFFF for any other req_len value.
- R4: A write to a missing target leaves fwd_valid at 0 and still gets its response strobe.
- R5: rsp_valid is 1 exactly in the cycle after each accepted request and 0 in the cycle after a cycle with no request.
- R6: A read hit returns, one cycle later on rsp_rdata, the value the slot presented on fwd_rdata in the request cycle.
- R7: A forwarded write carries fwd_write 1 and req_wdata unchanged. fwd_len is 1 or 2 when req_len is 1 or 2, and 4 otherwise.
- R8: alloc_idx is the lowest index of the form MIN_IDX + 8*k (k ≥ 0, index ≤ 255) whose presence bit is 0. alloc_ok is 1 when such an index exists.
- R9: alloc_ok is 0 when every candidate index is present. Presence bits at non-candidate indices, including those below MIN_IDX, do not affect the result.
- R10: alloc_dev equals alloc_idx[7:3] and alloc_func equals alloc_idx[2:0].
- R11: After reset, rsp_valid is 0 and rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Packed bus[23:16], index[15:8], register[7:0] |
| req_len | input | 3 | Access length code: 1, 2, otherwise 4 bytes |
| req_wdata | input | 32 | Write data |
| slot_present | input | 256 | Presence flag per device/function index |
| fwd_valid | output | 1 | Request forwarded to a present slot |
| fwd_write | output | 1 | Forwarded access is a write |
| fwd_slot | output | 8 | Target device/function index |
| fwd_reg | output | 8 | Register offset within the slot |
| fwd_len | output | 3 | Normalized length: 1, 2 or 4 |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_rdata | input | 32 | Read data from the addressed slot, same cycle |
| rsp_valid | output | 1 | Response strobe, one per request |
| rsp_rdata | output | 32 | Read result or all-ones fill |
| alloc_ok | output | 1 | A free candidate slot exists |
| alloc_idx | output | 8 | First free candidate index |
| alloc_dev | output | 5 | Device number of alloc_idx |
| alloc_func | output | 3 | Function number of alloc_idx |

## Verification
The slot port is combinational, so a decode fault shows the same cycle it happens: a wrong slot, register or hit flag appears on fwd_* while the request is still held. A fault in the response stage shows one cycle later as a missing or extra strobe or a wrongly sized fill, and nothing outlives the next request. Allocation faults show as a wrong index, a skipped candidate or a false failure flag as soon as the presence map settles.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} acc_size_e;

  // Length codes 1 and 2 keep their width; every other code is a word.
  function automatic acc_size_e size_of_len(input logic [2:0] len);
    case (len)
      3'd1:    return SZ_BYTE;
      3'd2:    return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

  function automatic logic [2:0] len_code(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // All-ones answer of the access width, zero-extended to the data bus.
  function automatic logic [DATA_W-1:0] fill_ones(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return DATA_W'(8'hFF);
      SZ_HALF: return DATA_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int BUS_W = 8,
  parameter int DFN_W = 8,
  parameter int REG_W = 8,
  localparam int ADDR_W = BUS_W + DFN_W + REG_W,
  localparam int NSLOT  = 1 << DFN_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSLOT-1:0]  present,
  output logic [DFN_W-1:0]  dfn,
  output logic [REG_W-1:0]  regoff,
  output logic              bus_zero,
  output logic              target_hit
);
  logic [BUS_W-1:0] bus;

  assign regoff     = addr[REG_W-1:0];
  assign dfn        = addr[REG_W +: DFN_W];
  assign bus        = addr[ADDR_W-1 -: BUS_W];
  assign bus_zero   = (bus == '0);
  assign target_hit = bus_zero & present[dfn];
endmodule

// File: rtl/cfg_rsp_stage.sv
module cfg_rsp_stage
  import cfg_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_len,
  input  logic              target_hit,
  input  logic [DATA_W-1:0] slot_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] next_data;
  logic              miss_read;

  assign miss_read = req_valid & ~req_write & ~target_hit;

  always_comb begin
    if (req_write)       next_data = '0;
    else if (target_hit) next_data = slot_rdata;
    else                 next_data = fill_ones(size_of_len(req_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_rdata <= next_data;
    end
  end

  // R5: a request is answered on the next cycle, and only then.
  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3: a missed read is filled with ones of its own width.
  a_r3_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
    miss_read |=> (rsp_rdata == $past(fill_ones(size_of_len(req_len)))));
endmodule

// File: rtl/cfg_slot_alloc.sv
module cfg_slot_alloc #(
  parameter int DFN_W   = 8,
  parameter int MIN_IDX = 8,
  parameter int STEP    = 8,
  localparam int NSLOT  = 1 << DFN_W,
  localparam int NCAND  = (NSLOT - 1 - MIN_IDX) / STEP + 1
) (
  input  logic [NSLOT-1:0] present,
  output logic             ok,
  output logic [DFN_W-1:0] idx
);
  logic [NCAND-1:0] cand_free;
  logic [DFN_W-1:0] cand_idx [NCAND];

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    localparam int IX = MIN_IDX + STEP * k;
    assign cand_idx[k]  = IX[DFN_W-1:0];
    assign cand_free[k] = ~present[IX];
  end

  // Lowest candidate wins: scan from the top so the last hit is the lowest.
  always_comb begin
    ok  = 1'b0;
    idx = '0;
    for (int k = NCAND - 1; k >= 0; k--) begin
      if (cand_free[k]) begin
        ok  = 1'b1;
        idx = cand_idx[k];
      end
    end
  end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
  import cfg_route_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DFN_W   = 8,
  parameter int REG_W   = 8,
  parameter int MIN_IDX = 8,
  localparam int ADDR_W = BUS_W + DFN_W + REG_W,
  localparam int NSLOT  = 1 << DFN_W,
  localparam int FN_W   = 3,
  localparam int DEV_W  = DFN_W - FN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_len,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NSLOT-1:0]  slot_present,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [DFN_W-1:0]  fwd_slot,
  output logic [REG_W-1:0]  fwd_reg,
  output logic [2:0]        fwd_len,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic [DATA_W-1:0] fwd_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              alloc_ok,
  output logic [DFN_W-1:0]  alloc_idx,
  output logic [DEV_W-1:0]  alloc_dev,
  output logic [FN_W-1:0]   alloc_func
);
  logic target_hit;
  logic bus_zero;

  cfg_addr_decode #(.BUS_W(BUS_W), .DFN_W(DFN_W), .REG_W(REG_W)) u_dec (
    .addr(req_addr), .present(slot_present), .dfn(fwd_slot),
    .regoff(fwd_reg), .bus_zero(bus_zero), .target_hit(target_hit));

  assign fwd_valid = req_valid & target_hit;
  assign fwd_write = req_write;
  assign fwd_len   = len_code(size_of_len(req_len));
  assign fwd_wdata = req_wdata;

  cfg_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_len(req_len), .target_hit(target_hit), .slot_rdata(fwd_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  cfg_slot_alloc #(.DFN_W(DFN_W), .MIN_IDX(MIN_IDX)) u_alloc (
    .present(slot_present), .ok(alloc_ok), .idx(alloc_idx));

  assign alloc_dev  = alloc_idx[DFN_W-1:FN_W];
  assign alloc_func = alloc_idx[FN_W-1:0];

  // R2: nothing leaves on the slot port for a bus other than zero.
  a_r2_other_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1 -: BUS_W] != '0) |-> !fwd_valid);
  // R4: a write forwarded to the slot port must target a present slot.
  a_r4_write_present: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_write) |-> slot_present[fwd_slot]);
  // R8: the proposed index is free and lies on the candidate grid.
  a_r8_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> !slot_present[alloc_idx]);
  a_r8_alloc_grid: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (int'(alloc_idx) >= MIN_IDX && alloc_idx[2:0] == MIN_IDX[2:0]));
  // R9: a failed allocation means the first candidate is taken.
  a_r9_fail_full: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ok |-> slot_present[MIN_IDX]);
endmodule

// File: tb/sim_cfg_route_top.sv
module sim_cfg_route_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [23:0]  req_addr = '0;
  logic [2:0]   req_len = 3'd4;
  logic [31:0]  req_wdata = '0;
  logic [255:0] slot_present = '0;
  wire          fwd_valid, fwd_write, rsp_valid, alloc_ok;
  wire  [7:0]   fwd_slot, fwd_reg, alloc_idx;
  wire  [2:0]   fwd_len, alloc_func;
  wire  [4:0]   alloc_dev;
  wire  [31:0]  fwd_wdata, rsp_rdata, fwd_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // Slot model: data names the slot and register it came from.
  assign fwd_rdata = {fwd_slot, fwd_reg, 16'hC0DE};

  cfg_route_top u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        c_fv, c_fw, r_v1, r_v2;
  logic [7:0]  c_slot, c_reg;
  logic [2:0]  c_len;
  logic [31:0] c_wd, r_d;

  task automatic do_req(input bit wr, input logic [23:0] a, input logic [2:0] l, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_len = l; req_wdata = wd;
    #1;
    c_fv = fwd_valid; c_fw = fwd_write; c_slot = fwd_slot; c_reg = fwd_reg;
    c_len = fwd_len; c_wd = fwd_wdata;
    @(negedge clk);
    req_valid = 0;
    r_v1 = rsp_valid; r_d = rsp_rdata;
    @(negedge clk);
    r_v2 = rsp_valid;
  endtask

  task automatic t_reset();
    check(rsp_valid == 0, "R11 rsp_valid after reset", rsp_valid, 0);
    check(rsp_rdata == 0, "R11 rsp_rdata after reset", rsp_rdata, 0);
  endtask

  task automatic t_hit_read();
    slot_present[8'h13] = 1;
    do_req(0, 24'h00_13_44, 3'd4, 0);
    check(c_fv == 1, "R1 fwd_valid on hit", c_fv, 1);
    check(c_slot == 8'h13, "R1 fwd_slot", c_slot, 8'h13);
    check(c_reg == 8'h44, "R1 fwd_reg", c_reg, 8'h44);
    check(r_v1 == 1, "R5 strobe after read", r_v1, 1);
    check(r_v2 == 0, "R5 single strobe", r_v2, 0);
    check(r_d == 32'h1344C0DE, "R6 read hit data", r_d, 32'h1344C0DE);
  endtask

  task automatic t_other_bus();
    do_req(0, 24'h01_13_44, 3'd2, 0);
    check(c_fv == 0, "R2 other bus not forwarded", c_fv, 0);
    check(r_d == 32'h0000FFFF, "R2 other bus read fill", r_d, 32'h0000FFFF);
  endtask

  task automatic t_miss_fill();
    do_req(0, 24'h00_20_00, 3'd1, 0);
    check(r_d == 32'h000000FF, "R3 fill len1", r_d, 32'h000000FF);
    do_req(0, 24'h00_20_04, 3'd2, 0);
    check(r_d == 32'h0000FFFF, "R3 fill len2", r_d, 32'h0000FFFF);
    do_req(0, 24'h00_20_08, 3'd4, 0);
    check(r_d == 32'hFFFFFFFF, "R3 fill len4", r_d, 32'hFFFFFFFF);
    do_req(0, 24'h00_20_0C, 3'd7, 0);
    check(r_d == 32'hFFFFFFFF, "R3 fill len7", r_d, 32'hFFFFFFFF);
    do_req(0, 24'h00_20_0C, 3'd0, 0);
    check(r_d == 32'hFFFFFFFF, "R3 fill len0", r_d, 32'hFFFFFFFF);
  endtask

  task automatic t_miss_write();
    do_req(1, 24'h00_21_10, 3'd4, 32'hDEADBEEF);
    check(c_fv == 0, "R4 missed write dropped", c_fv, 0);
    check(r_v1 == 1, "R4 missed write answered", r_v1, 1);
    check(r_v2 == 0, "R5 missed write single strobe", r_v2, 0);
  endtask

  task automatic t_hit_write();
    do_req(1, 24'h00_13_3C, 3'd2, 32'h12345678);
    check(c_fv == 1 && c_fw == 1, "R7 write forwarded", {c_fv, c_fw}, 2'b11);
    check(c_wd == 32'h12345678, "R7 write data", c_wd, 32'h12345678);
    check(c_len == 3'd2, "R7 len2", c_len, 2);
    do_req(1, 24'h00_13_3C, 3'd6, 32'h0);
    check(c_len == 3'd4, "R7 len6 as 4", c_len, 4);
    do_req(1, 24'h00_13_3C, 3'd1, 32'h0);
    check(c_len == 3'd1, "R7 len1", c_len, 1);
  endtask

  task automatic t_idle();
    @(negedge clk); @(negedge clk);
    check(rsp_valid == 0, "R5 idle no strobe", rsp_valid, 0);
  endtask

  task automatic t_alloc();
    slot_present = '0;
    #1;
    check(alloc_ok && alloc_idx == 8'd8, "R8 first candidate", alloc_idx, 8);
    check(alloc_dev == 5'd1 && alloc_func == 3'd0, "R10 dev/func split", {alloc_dev, alloc_func}, 8'h08);
    slot_present[8] = 1; slot_present[16] = 1; slot_present[17] = 1;
    #1;
    check(alloc_ok && alloc_idx == 8'd24, "R8 skip taken", alloc_idx, 24);
    check(alloc_dev == 5'd3 && alloc_func == 3'd0, "R10 dev 3", {alloc_dev, alloc_func}, 8'h18);
    for (int k = 0; k < 31; k++) slot_present[8 + 8 * k] = 1;
    slot_present[0] = 0; slot_present[9] = 0;
    #1;
    check(alloc_ok == 0, "R9 all candidates taken", alloc_ok, 0);
    slot_present[248] = 0;
    #1;
    check(alloc_ok && alloc_idx == 8'd248, "R8 last candidate", alloc_idx, 248);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hit_read();
    t_other_bus();
    t_miss_fill();
    t_miss_write();
    t_hit_write();
    t_idle();
    t_alloc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule